// File: doc/BRIEF.md
# Three-Pin GPIO Port with Pull-Up Control

This block is a small general-purpose I/O port of three pins behind a synchronous register bus. Software sets each pin's direction through a direction register, sets the driven levels through an output latch register, and reads pin levels through a combined port register. The combined port register also holds two global weak pull-up enables: one for this port and one that is handed to a neighbouring port.

On the pad side the block drives an output enable, an output level and a pull-up enable for every pin. Pin inputs are taken to be clean digital levels already. They pass through a two-flop synchronizer before software can read them. A per-pin analog-select input forces that pin's digital read value to zero. Analog select leaves the pin's driver alone, so the direction bit still decides whether the pad drives.

The bus has no handshake. A write is taken on the rising clock edge when the write strobe is high. Read data is a combinational function of the address and the current state.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction register reads 3'b111 (all inputs), the latch reads 0, and both pull-up enables read 0. This gives pad_oe = 0, pad_out = 0, pad_pu = 0 and nbr_pu_en = 0.
- R2: The direction register sits at address 2 in bits [2:0], and 1 means input. pad_oe[i] equals the inverse of direction bit i. A read at address 2 returns 0 in bits [7:3].
- R3: The latch register sits at address 1. A write stores bits [2:0], and pad_out follows the stored value. A read at address 1 returns the stored value in bits [2:0] and 0 in bits [7:3], whatever the pin levels are.
- R4: The port register sits at address 0. A write there copies bits [2:0] into the latch. Bits [5:3] of a port write are ignored, and a port read returns 0 in bits [5:3].
- R5: Port register bit 6 (this port's pull-up enable) and bit 7 (the neighbour's pull-up enable) are written by a port write and read back in the same positions.
- R6: pad_pu[i] is 1 exactly when port bit 6 is 1 and direction bit i is 1. A pin configured as output never has its pull-up on.
- R7: nbr_pu_en always equals port register bit 7.
- R8: A port read returns the pin levels in bits [2:0] through a two-flop synchronizer. A level applied before one rising edge is not yet visible after that edge, and becomes visible after the next rising edge.
- R9: When ana_sel[i] is 1, bit i of a port read is 0 with no added delay. The direction register, pad_oe and pad_pu do not depend on ana_sel.
- R10: Address 3 is unmapped. It reads 0, and writes to it change no register.
- R11: A write takes effect at the rising edge where bus_wr is 1. Reads are combinational in bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 unmapped |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 3 | Digital pin levels from the pads |
| ana_sel | input | 3 | Per-pin analog select; 1 forces the digital read to 0 |
| pad_oe | output | 3 | Pad output enable, 1 = drive |
| pad_out | output | 3 | Pad output level |
| pad_pu | output | 3 | Pad weak pull-up enable |
| nbr_pu_en | output | 1 | Global pull-up enable for the neighbouring port |

## Verification
A wrong direction bit shows on pad_oe and on pad_pu in the cycle after the write that set it. A lost or corrupted latch bit shows on pad_out and in latch reads at once. A synchronizer with the wrong number of stages shows up as a port read that changes one edge too early or one edge too late. The bench therefore samples the port read after each single edge. Pin levels differ from the latch contents during the latch sweep, so any accidental read of pins through the latch address appears immediately. The bench sweeps every direction value against every pull-up enable combination, and every pin pattern against every analog-select pattern.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned REG_DATA_W = 8;
  localparam logic [REG_ADDR_W-1:0] ADDR_PORT = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_LAT  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_DIR  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_NONE = 2'd3;
  // bit positions inside the port register that software relies on
  localparam int unsigned PU_SELF_BIT = 6;
  localparam int unsigned PU_NBR_BIT  = 7;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

  // cycles since reset, saturating, gates the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (q_sync == $past(d_async, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [REG_DATA_W-1:0] wdata,
  output logic [PIN_W-1:0]      dir_q,
  output logic [PIN_W-1:0]      lat_q,
  output logic                  pu_self_q,
  output logic                  pu_nbr_q
);
  logic wr_port, wr_lat, wr_dir;
  assign wr_port = wr && (addr == ADDR_PORT);
  assign wr_lat  = wr && (addr == ADDR_LAT);
  assign wr_dir  = wr && (addr == ADDR_DIR);

  // bits of a write that no register keeps
  logic unused_wbits;
  assign unused_wbits = ^wdata[PU_SELF_BIT-1:PIN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '1;
      lat_q     <= '0;
      pu_self_q <= 1'b0;
      pu_nbr_q  <= 1'b0;
    end else begin
      if (wr_dir) dir_q <= wdata[PIN_W-1:0];
      if (wr_lat || wr_port) lat_q <= wdata[PIN_W-1:0];
      if (wr_port) begin
        pu_self_q <= wdata[PU_SELF_BIT];
        pu_nbr_q  <= wdata[PU_NBR_BIT];
      end
    end
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_DIR) |=> (dir_q == $past(wdata[PIN_W-1:0])));
  p_lat_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_LAT) |=> (lat_q == $past(wdata[PIN_W-1:0])));
  p_port_to_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_PORT) |=> (lat_q == $past(wdata[PIN_W-1:0])));
  p_pu_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_PORT) |=>
      (pu_self_q == $past(wdata[PU_SELF_BIT]) && pu_nbr_q == $past(wdata[PU_NBR_BIT])));
  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_NONE) |=>
      ($stable(dir_q) && $stable(lat_q) && $stable(pu_self_q) && $stable(pu_nbr_q)));
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
  parameter int unsigned PIN_W = 3
) (
  input  logic [PIN_W-1:0] dir,
  input  logic [PIN_W-1:0] lat,
  input  logic             pu_self,
  input  logic [PIN_W-1:0] pin_sync,
  input  logic [PIN_W-1:0] ana_sel,
  output logic [PIN_W-1:0] pad_oe,
  output logic [PIN_W-1:0] pad_out,
  output logic [PIN_W-1:0] pad_pu,
  output logic [PIN_W-1:0] pin_rd
);
  generate
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      // direction keeps control of the driver even for analog pins
      assign pad_oe[i]  = ~dir[i];
      assign pad_out[i] = lat[i];
      assign pad_pu[i]  = pu_self & dir[i];
      assign pin_rd[i]  = pin_sync[i] & ~ana_sel[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_W = 3
) (
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]      dir,
  input  logic [PIN_W-1:0]      lat,
  input  logic                  pu_self,
  input  logic                  pu_nbr,
  input  logic [PIN_W-1:0]      pin_rd,
  output logic [REG_DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_PORT: begin
        rdata[PIN_W-1:0]   = pin_rd;
        rdata[PU_SELF_BIT] = pu_self;
        rdata[PU_NBR_BIT]  = pu_nbr;
      end
      ADDR_LAT: rdata[PIN_W-1:0] = lat;
      ADDR_DIR: rdata[PIN_W-1:0] = dir;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [REG_DATA_W-1:0] bus_wdata,
  output logic [REG_DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]      pin_in,
  input  logic [PIN_W-1:0]      ana_sel,
  output logic [PIN_W-1:0]      pad_oe,
  output logic [PIN_W-1:0]      pad_out,
  output logic [PIN_W-1:0]      pad_pu,
  output logic                  nbr_pu_en
);
  logic [PIN_W-1:0] dir_q, lat_q, pin_sync, pin_rd;
  logic             pu_self_q, pu_nbr_q;

  gpio_port_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_sync));

  gpio_port_regs #(.PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .dir_q(dir_q), .lat_q(lat_q), .pu_self_q(pu_self_q), .pu_nbr_q(pu_nbr_q));

  gpio_port_pad #(.PIN_W(PIN_W)) u_pad (
    .dir(dir_q), .lat(lat_q), .pu_self(pu_self_q), .pin_sync(pin_sync),
    .ana_sel(ana_sel), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pin_rd(pin_rd));

  gpio_port_rdmux #(.PIN_W(PIN_W)) u_rdmux (
    .addr(bus_addr), .dir(dir_q), .lat(lat_q), .pu_self(pu_self_q),
    .pu_nbr(pu_nbr_q), .pin_rd(pin_rd), .rdata(bus_rdata));

  assign nbr_pu_en = pu_nbr_q;

  p_pu_off_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
  p_pu_global_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_PORT && !bus_wdata[PU_SELF_BIT]) |=> (pad_pu == '0));
  p_nbr_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_PORT) |=> (nbr_pu_en == $past(bus_wdata[PU_NBR_BIT])));
  p_analog_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_PORT) |-> ((bus_rdata[PIN_W-1:0] & ana_sel) == '0));
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_PORT) |-> (bus_rdata[PU_SELF_BIT-1:PIN_W] == '0));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [2:0] pin_in = 3'd0;
  logic [2:0] ana_sel = 3'd0;
  logic [2:0] pad_oe, pad_out, pad_pu;
  logic       nbr_pu_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .ana_sel(ana_sel), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .nbr_pu_en(nbr_pu_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rv;
    logic [7:0] before_dir, before_lat, before_port;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(2'd2, rv); chk("R1 dir reset", rv, 8'h07);
    rd_reg(2'd1, rv); chk("R1 lat reset", rv, 8'h00);
    rd_reg(2'd0, rv); chk("R1 port reset", rv, 8'h00);
    chk("R1 pad_oe reset", pad_oe, 0);
    chk("R1 pad_out reset", pad_out, 0);
    chk("R1 pad_pu reset", pad_pu, 0);
    chk("R1 nbr reset", nbr_pu_en, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(2);

    // R2 R4 R5 R6 R7: every direction against every pull-up combination
    for (int d = 0; d < 8; d++) begin
      for (int p = 0; p < 4; p++) begin
        wr_reg(2'd2, 8'hF8 | 8'(d));
        wr_reg(2'd0, {p[1:0], 3'b111, 3'(7 - d)});
        rd_reg(2'd2, rv); chk("R2 dir read", rv, d);
        chk("R2 pad_oe", pad_oe, (~d) & 7);
        chk("R6 pad_pu gating", pad_pu, p[0] ? d : 0);
        chk("R7 nbr_pu_en", nbr_pu_en, p[1]);
        rd_reg(2'd0, rv);
        chk("R5 pull-up bits", rv[7:6], p);
        chk("R4 reserved zero", rv[5:3], 0);
        rd_reg(2'd1, rv); chk("R4 port write to latch", rv, 7 - d);
        chk("R4 pad_out", pad_out, 7 - d);
      end
    end

    // R3 latch sweep, pins held at the complement
    for (int v = 0; v < 8; v++) begin
      pin_in = 3'(~v);
      wr_reg(2'd1, 8'hF8 | 8'(v));
      cycles(2);
      rd_reg(2'd1, rv); chk("R3 latch read", rv, v);
      chk("R3 pad_out", pad_out, v);
    end

    // R8 R9: every pin pattern against every analog pattern
    wr_reg(2'd2, 8'h02);
    wr_reg(2'd0, 8'h40);
    for (int pv = 0; pv < 8; pv++) begin
      pin_in = 3'(pv);
      cycles(3);
      for (int a = 0; a < 8; a++) begin
        ana_sel = 3'(a);
        rd_reg(2'd0, rv);
        chk("R9 analog mask read", rv[2:0], pv & ~a & 7);
        chk("R9 pad_oe unaffected", pad_oe, 3'b101);
        chk("R9 pad_pu unaffected", pad_pu, 3'b010);
        rd_reg(2'd2, rv); chk("R9 dir unaffected", rv, 8'h02);
      end
      ana_sel = 3'd0;
    end

    // R8 R11 synchronizer latency, one edge at a time
    bus_addr = 2'd0;
    @(negedge clk); pin_in = 3'd0;
    cycles(3);
    pin_in = 3'b101;
    @(negedge clk); #1; chk("R8 not visible after one edge", bus_rdata[2:0], 0);
    @(negedge clk); #1; chk("R8 visible after two edges", bus_rdata[2:0], 3'b101);
    pin_in = 3'b010;
    @(negedge clk); #1; chk("R8 old after one edge", bus_rdata[2:0], 3'b101);
    @(negedge clk); #1; chk("R8 new after two edges", bus_rdata[2:0], 3'b010);

    // R11 write visible only after its edge
    @(negedge clk);
    bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = 8'h06;
    #1; chk("R11 before edge", bus_rdata, 8'h00);
    @(negedge clk); bus_wr = 1'b0; #1;
    chk("R11 after edge", bus_rdata, 8'h06);

    // R10 unmapped address
    wr_reg(2'd0, 8'hC1);
    rd_reg(2'd2, before_dir); rd_reg(2'd1, before_lat); rd_reg(2'd0, before_port);
    wr_reg(2'd3, 8'h3E);
    rd_reg(2'd3, rv); chk("R10 unmapped read", rv, 0);
    rd_reg(2'd2, rv); chk("R10 dir kept", rv, before_dir);
    rd_reg(2'd1, rv); chk("R10 lat kept", rv, before_lat);
    rd_reg(2'd0, rv); chk("R10 port kept", rv, before_port);
    chk("R10 nbr kept", nbr_pu_en, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule